// File: doc/BRIEF.md
# Parity-Stream Single-Lane Corrector

This block sits after four parallel transform engines that run side by side, plus one extra engine whose input is the sum of the four original inputs. Because the transform is linear, the extra engine's output, here called the parity stream, equals the sum of the four lane outputs. Each lane also has an energy-check circuit that raises a per-lane flag when that lane's transform looks wrong. The corrector takes the four lane samples, the parity sample and the four flags, all aligned to the same sample. It repairs the one lane that the flags point at by rebuilding it as the parity sample minus the other three lanes.

The flags describe a whole frame. The corrector latches them on the frame's first sample, which is marked by a start-of-frame strobe, and applies them to every sample up to the next strobe. When exactly one flag is set, that lane is replaced with its rebuilt value. When no flag is set, or more than one flag is set, the samples pass through unchanged. When more than one flag is set, an uncorrectable status bit is raised. Real and imaginary parts are handled independently.

Every output is registered once, so results appear one clock after the matching input sample.

Top module: `parity_stream_corrector`

## Requirements
- R1: During and after a synchronous reset, `out_valid`, `out_fixed` and `out_uncorr` are 0. The latched frame flags are cleared, so a non-start sample that follows reset passes unchanged.
- R2: `out_valid` and `out_sof` equal `in_valid` and `in_sof` one clock later. While `out_valid` is 0, `out_fixed` and `out_uncorr` are 0.
- R3: With no latched flag set, each lane of `out_re`/`out_im` equals the same lane of `in_re`/`in_im` one clock later, and `out_fixed` is 0.
- R4: With exactly one latched flag set (bit k of `chk_flag` corresponds to lane k), output lane k is the parity sample minus the other three lanes, taking the low W bits. This is done separately for the real and imaginary parts. The other lanes pass unchanged, and `out_fixed` has only bit k set.
- R5: Flags are sampled only on a valid sample with `in_sof`=1. They are held for every following valid sample until the next start. `chk_flag` on any other sample has no effect.
- R6: With two or more latched flags set, all lanes pass unchanged, `out_uncorr`=1 and `out_fixed`=0.
- R7: A flag on a lane whose data is actually correct still produces the correct value, equal to the raw lane.
- R8: A corrupted parity sample with no flag set leaves all lane outputs equal to the raw lanes.
- R9: Rebuilding uses arithmetic wide enough that lane values at the signed extremes (-2^(W-1) and 2^(W-1)-1) are reconstructed exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_sof | input | 1 | Marks the first sample of a frame |
| in_re | input | LANES*W | Real parts of the four lane samples, lane k in slice k |
| in_im | input | LANES*W | Imaginary parts of the four lane samples |
| par_re | input | W+2 | Real part of the parity sample (signed) |
| par_im | input | W+2 | Imaginary part of the parity sample (signed) |
| chk_flag | input | LANES | Per-lane energy-check fault flags, bit k for lane k |
| out_valid | output | 1 | Output sample valid |
| out_sof | output | 1 | Start-of-frame mark, delayed |
| out_re | output | LANES*W | Corrected real parts |
| out_im | output | LANES*W | Corrected imaginary parts |
| out_fixed | output | LANES | One-hot: the lane rebuilt in this sample |
| out_uncorr | output | 1 | More than one flag is set for this frame |

## Verification
Two functions can act in the same cycle: a frame start that loads new flags, and the rebuild that uses them. The bench checks that a start sample is corrected with its own flags and not with those of the previous frame. It provokes this with back-to-back starts whose flag patterns differ, and with a non-start sample that carries a conflicting flag pattern. In each case the output lanes are judged against values computed from the parity sum. A second collision is a reset that arrives in the middle of a flagged frame; the bench checks that the next non-start sample is no longer rebuilt.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int PSC_LANES    = 4;
    localparam int PSC_SAMPLE_W = 16;
    localparam int PSC_GUARD    = $clog2(PSC_LANES);

    typedef struct packed {
        logic [PSC_LANES-1:0] pick;   // one-hot lane to rebuild, or zero
        logic                 multi;  // more than one flag set
    } psc_dec_t;

    function automatic int unsigned psc_popcount(input logic [PSC_LANES-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < PSC_LANES; i++) begin
            n = n + int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/psc_flag_hold.sv
module psc_flag_hold
    import psc_pkg::*;
#(
    parameter int LANES = PSC_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [LANES-1:0] chk_flag,
    output psc_dec_t         dec
);

    logic [LANES-1:0] held_q;
    logic [LANES-1:0] eff;
    logic             take;
    int unsigned      nset;

    assign take = in_valid && in_sof;

    // a start sample uses its own flags in the same cycle it loads them
    always_comb begin
        eff = take ? chk_flag : held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (take) begin
            held_q <= chk_flag;
        end
    end

    always_comb begin
        nset      = psc_popcount(eff);
        dec.pick  = (nset == 1) ? eff : '0;
        dec.multi = (nset > 1);
    end

    // R5
    hold_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sof) |=> (held_q == $past(held_q)));

endmodule

// File: rtl/psc_rebuild.sv
module psc_rebuild
    import psc_pkg::*;
#(
    parameter int LANES = PSC_LANES,
    parameter int W     = PSC_SAMPLE_W,
    parameter int PW    = W + $clog2(LANES)
) (
    input  logic [LANES-1:0][W-1:0] lane_in,
    input  logic [PW-1:0]           par_in,
    output logic [LANES-1:0][W-1:0] rebuilt
);

    localparam int AW = PW + 1;

    logic [LANES-1:0][AW-1:0] lane_x;
    logic [AW-1:0]            total;
    logic [AW-1:0]            par_x;

    assign par_x = {par_in[PW-1], par_in};

    for (genvar k = 0; k < LANES; k++) begin : g_ext
        assign lane_x[k] = {{(AW-W){lane_in[k][W-1]}}, lane_in[k]};
    end

    always_comb begin
        total = '0;
        for (int k = 0; k < LANES; k++) begin
            total = total + lane_x[k];
        end
    end

    // one shared sum; each lane removes only itself from it
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rebuilt[k] = W'(par_x - (total - lane_x[k]));
    end

endmodule

// File: rtl/parity_stream_corrector.sv
module parity_stream_corrector
    import psc_pkg::*;
#(
    parameter int LANES = PSC_LANES,
    parameter int W     = PSC_SAMPLE_W,
    parameter int PW    = W + $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [LANES-1:0][W-1:0] in_re,
    input  logic [LANES-1:0][W-1:0] in_im,
    input  logic [PW-1:0]           par_re,
    input  logic [PW-1:0]           par_im,
    input  logic [LANES-1:0]        chk_flag,
    output logic                    out_valid,
    output logic                    out_sof,
    output logic [LANES-1:0][W-1:0] out_re,
    output logic [LANES-1:0][W-1:0] out_im,
    output logic [LANES-1:0]        out_fixed,
    output logic                    out_uncorr
);

    psc_dec_t                dec;
    logic [LANES-1:0][W-1:0] reb_re;
    logic [LANES-1:0][W-1:0] reb_im;

    psc_flag_hold #(.LANES(LANES)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .chk_flag (chk_flag),
        .dec      (dec)
    );

    psc_rebuild #(.LANES(LANES), .W(W), .PW(PW)) u_reb_re (
        .lane_in (in_re),
        .par_in  (par_re),
        .rebuilt (reb_re)
    );

    psc_rebuild #(.LANES(LANES), .W(W), .PW(PW)) u_reb_im (
        .lane_in (in_im),
        .par_in  (par_im),
        .rebuilt (reb_im)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sof    <= 1'b0;
            out_fixed  <= '0;
            out_uncorr <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_sof    <= in_valid && in_sof;
            out_fixed  <= in_valid ? dec.pick : '0;
            out_uncorr <= in_valid && dec.multi;
        end
    end

    // output multiplexers: raw or rebuilt per lane
    for (genvar k = 0; k < LANES; k++) begin : g_mux
        always_ff @(posedge clk) begin
            if (rst) begin
                out_re[k] <= '0;
                out_im[k] <= '0;
            end else if (in_valid) begin
                out_re[k] <= dec.pick[k] ? reb_re[k] : in_re[k];
                out_im[k] <= dec.pick[k] ? reb_im[k] : in_im[k];
            end
        end
    end

    // R4
    fixed_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_fixed));

    // R6
    fixed_uncorr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_uncorr |-> (out_fixed == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    status_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_fixed == '0 && !out_uncorr));

    // R3
    pass_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fixed == '0) |-> (out_re == $past(in_re) && out_im == $past(in_im)));

    // R5
    frame_status_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sof && out_valid) |=>
            (out_fixed == $past(out_fixed) && out_uncorr == $past(out_uncorr)));

endmodule

// File: tb/parity_stream_corrector_tb.sv
`timescale 1ns/1ps
module parity_stream_corrector_tb;

    localparam int L  = 4;
    localparam int W  = 16;
    localparam int PW = 18;

    // entry: {sof, flags[3:0], corrupt[3:0]}; corrupt 0..3 = lane, 4 = parity, 15 = none
    localparam logic [8:0] VEC [12] = '{
        {1'b1, 4'b0000, 4'd15},   // R3
        {1'b0, 4'b0000, 4'd15},   // R3
        {1'b1, 4'b0001, 4'd0},    // R4
        {1'b0, 4'b0000, 4'd0},    // R5 flags ignored, held 0001
        {1'b1, 4'b0100, 4'd2},    // R4
        {1'b1, 4'b1000, 4'd15},   // R7
        {1'b1, 4'b0000, 4'd4},    // R8
        {1'b1, 4'b0011, 4'd1},    // R6
        {1'b0, 4'b0010, 4'd1},    // R5 held 0011
        {1'b1, 4'b0010, 4'd1},    // R4 new start, new flags
        {1'b0, 4'b1111, 4'd15},   // R5 held 0010
        {1'b1, 4'b0000, 4'd15}    // R3
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_sof = 1'b0;
    logic [L-1:0][W-1:0] in_re = '0;
    logic [L-1:0][W-1:0] in_im = '0;
    logic [PW-1:0]       par_re = '0;
    logic [PW-1:0]       par_im = '0;
    logic [L-1:0]        chk_flag = '0;
    logic                out_valid, out_sof, out_uncorr;
    logic [L-1:0][W-1:0] out_re, out_im;
    logic [L-1:0]        out_fixed;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic [L-1:0] model_held = '0;

    always #10 clk = ~clk;

    parity_stream_corrector u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_re(in_re), .in_im(in_im), .par_re(par_re), .par_im(par_im),
        .chk_flag(chk_flag), .out_valid(out_valid), .out_sof(out_sof),
        .out_re(out_re), .out_im(out_im), .out_fixed(out_fixed), .out_uncorr(out_uncorr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // builds a consistent parity from the current lanes, then applies the corruption code
    task automatic load_lanes(input int seed, input logic [3:0] cr);
        int sr, si;
        sr = 0; si = 0;
        for (int l = 0; l < L; l++) begin
            in_re[l] = 16'(seed * 7919 + l * 12345 + 311);
            in_im[l] = 16'(seed * 4093 - l * 23456 + 97);
            sr = sr + int'($signed(in_re[l]));
            si = si + int'($signed(in_im[l]));
        end
        par_re = PW'(sr + ((cr == 4'd4) ? 85 : 0));
        par_im = PW'(si + ((cr == 4'd4) ? 85 : 0));
        if (cr < 4'd4) begin
            in_re[cr[1:0]] = in_re[cr[1:0]] + 16'h0123;
            in_im[cr[1:0]] = in_im[cr[1:0]] + 16'h0123;
        end
    endtask

    // drives the current inputs for one sample and checks the registered result
    task automatic run_sample(input logic sof, input logic [3:0] fl, input string req);
        logic [L-1:0][W-1:0] e_re, e_im;
        logic [L-1:0]        e_fix;
        int                  cnt;
        in_valid = 1'b1;
        in_sof   = sof;
        chk_flag = fl;
        if (sof) model_held = fl;
        cnt = $countones(model_held);
        e_fix = (cnt == 1) ? model_held : '0;
        for (int l = 0; l < L; l++) begin
            if (e_fix[l]) begin
                int ar, ai;
                ar = int'($signed(par_re));
                ai = int'($signed(par_im));
                for (int j = 0; j < L; j++) begin
                    if (j != l) begin
                        ar = ar - int'($signed(in_re[j]));
                        ai = ai - int'($signed(in_im[j]));
                    end
                end
                e_re[l] = 16'(ar);
                e_im[l] = 16'(ai);
            end else begin
                e_re[l] = in_re[l];
                e_im[l] = in_im[l];
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, "out_valid", 32'(out_valid), 32'd1);
        chk(req, "out_sof", 32'(out_sof), 32'(sof));
        chk(req, "out_fixed", 32'(out_fixed), 32'(e_fix));
        chk(req, "out_uncorr", 32'(out_uncorr), 32'(cnt > 1));
        for (int l = 0; l < L; l++) begin
            chk(req, $sformatf("re lane %0d", l), 32'(out_re[l]), 32'(e_re[l]));
            chk(req, $sformatf("im lane %0d", l), 32'(out_im[l]), 32'(e_im[l]));
        end
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "out_fixed", 32'(out_fixed), 32'd0);
        chk("R1", "out_uncorr", 32'(out_uncorr), 32'd0);
        rst = 1'b0;

        for (int v = 0; v < 12; v++) begin
            logic [8:0] e;
            e = VEC[v];
            load_lanes(v + 1, e[3:0]);
            run_sample(e[8], e[7:4], $sformatf("R3/R4/R5/R6/R7/R8 vec%0d", v));
        end

        // R2 idle: out_valid and status drop one clock after in_valid drops
        in_valid = 1'b0;
        chk_flag = 4'b0001;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "out_valid idle", 32'(out_valid), 32'd0);
        chk("R2", "out_fixed idle", 32'(out_fixed), 32'd0);

        // R9 signed extremes, lane 1 corrupted and flagged
        in_re[0] = 16'h8000; in_re[1] = 16'h7FFF; in_re[2] = 16'h7FFF; in_re[3] = 16'h8000;
        in_im[0] = 16'h7FFF; in_im[1] = 16'h8000; in_im[2] = 16'h8000; in_im[3] = 16'h8000;
        par_re = PW'(-32768 + 32767 + 32767 - 32768);
        par_im = PW'(32767 - 32768 - 32768 - 32768);
        in_re[1] = 16'h0000;
        in_im[1] = 16'h0000;
        run_sample(1'b1, 4'b0010, "R9");
        chk("R9", "lane1 re exact", 32'(out_re[1]), 32'h7FFF);
        chk("R9", "lane1 im exact", 32'(out_im[1]), 32'h8000);

        // R1 reset mid-frame clears latched flags
        load_lanes(50, 4'd15);
        run_sample(1'b1, 4'b0001, "R1 pre");
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        model_held = '0;
        load_lanes(51, 4'd0);
        run_sample(1'b0, 4'b0000, "R1 post");

        in_valid = 1'b0;
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule